// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Commands

This block is a watchdog timer that runs from its own free-running clock. A programmable prescaler divides that clock by a power of two between 1 and 128. Each prescaler tick advances an 8-bit main counter. When the main counter overflows, the watchdog sets a time-out flag. If the system is running, it also raises a one-cycle reset request. If the system is halted, it raises a one-cycle wake-up pulse instead. A power-down flag records that a halt command was taken.

Software keeps the watchdog alive with clear commands. There are two distinct clear strobes, A and B.
- In single-command mode, either strobe on its own restarts the watchdog.
- In paired mode, a restart needs one strobe followed by the other. Repeating the same strobe does nothing. Once a pair completes, the pending state is forgotten, so the next restart needs a fresh pair.

A halt strobe restarts the count, sets the power-down flag and clears the time-out flag. The instruction decoder that produces the strobes and the reset generator that acts on the reset request are outside this block. All inputs are synchronous to the watchdog clock.

Top module: `wdog_dualclr`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `to_flag`, `pd_flag`, `rst_req` and `wake` are 0. All counters start from zero, so with `div_sel`=0 the first time-out appears 256 cycles after the last reset edge.
- R2: The prescaler ratio is 2^`div_sel` (`div_sel`=0 gives 1:1, 7 gives 1:128). After a restart, `to_flag` rises exactly 256·2^`div_sel` clock edges after the restarting edge.
- R3: With `two_cmd`=0, a cycle in which exactly one of `clr_a`/`clr_b` is high restarts the watchdog. It clears `to_flag` and `pd_flag` on that edge.
- R4: With `two_cmd`=1, a strobe on one clear input, with the most recent clear strobe having been the other input, restarts the watchdog and clears both flags. This holds for A then B and for B then A.
- R5: With `two_cmd`=1, repeating the same clear strobe without the other one changes neither the count nor the flags.
- R6: After a completed pair, the pending state is empty. A single following strobe does not restart the watchdog.
- R7: A `halt` strobe restarts the count and prescaler, sets `pd_flag` and clears `to_flag`. It takes priority over a clear strobe in the same cycle and empties the pending clear state.
- R8: An overflow while `pd_flag`=0 sets `to_flag` and raises `rst_req` for exactly one cycle, in the same edge.
- R9: An overflow while `pd_flag`=1 sets `to_flag` and raises `wake` for exactly one cycle, leaving `pd_flag` at 1. `wake` and `rst_req` are never high together.
- R10: A cycle with both `clr_a` and `clr_b` high counts as no clear command in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog's own free-running clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| div_sel | input | 3 | Prescaler select, ratio 2^div_sel |
| two_cmd | input | 1 | 1 = paired clear mode, 0 = single-command mode |
| clr_a | input | 1 | Clear command A strobe |
| clr_b | input | 1 | Clear command B strobe |
| halt | input | 1 | Halt / power-down command strobe |
| to_flag | output | 1 | Time-out flag |
| pd_flag | output | 1 | Power-down flag |
| rst_req | output | 1 | One-cycle reset request on time-out while running |
| wake | output | 1 | One-cycle wake-up on time-out while halted |

## Verification
Every command acts on the rising edge that samples its strobe, so the flags are due at the next falling edge. A time-out is due exactly 256·2^`div_sel` edges after the restarting edge, and its pulse lasts one cycle. The bench drives strobes at falling edges and counts edges from the restarting edge. It samples one edge before the expected overflow, when nothing may have changed, and again at the overflow edge. The sweep covers all eight prescaler settings this way. The command-ordering cases use the 1:1 setting, with edge offsets worked out so that an ignored strobe shows as a time-out that arrives on the original schedule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Which clear command is waiting for its partner in paired mode
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_A    = 2'd1,
        PEND_B    = 2'd2
    } pend_e;

    // Decoded command for the counter core
    typedef struct packed {
        logic halt;
        logic restart;
    } wd_cmd_t;

    // Status flags
    typedef struct packed {
        logic to;
        logic pd;
    } wd_flags_t;

    // Event pulses raised on overflow
    typedef struct packed {
        logic rst_req;
        logic wake;
    } wd_evt_t;

    // Next pending state after one cycle of command input
    function automatic pend_e next_pend(pend_e cur, logic a_only, logic b_only,
                                        logic fire, logic flush);
        pend_e n;
        n = cur;
        if (flush || fire) n = PEND_NONE;
        else if (a_only)   n = PEND_A;
        else if (b_only)   n = PEND_B;
        return n;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Bit i takes part in the terminal-count test when the ratio exceeds 2^i
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    assign tick = &(pre_q | ~mask);

    always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else            pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/wdog_clr_arb.sv
module wdog_clr_arb
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic two_cmd,
    input  logic clr_a,
    input  logic clr_b,
    input  logic halt,
    output logic fire
);
    pend_e pend_q;
    logic  a_only, b_only;

    assign a_only = clr_a & ~clr_b;
    assign b_only = clr_b & ~clr_a;

    always_comb begin
        if (!two_cmd) fire = a_only | b_only;
        else          fire = (a_only && pend_q == PEND_B) ||
                             (b_only && pend_q == PEND_A);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= PEND_NONE;
        else     pend_q <= next_pend(pend_q, a_only, b_only, fire,
                                     halt | ~two_cmd);
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  wd_cmd_t   cmd,
    output wd_flags_t flags,
    output wd_evt_t   evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            flags <= '0;
            evt   <= '0;
        end else begin
            evt <= '0;
            if (cmd.halt) begin
                cnt_q    <= '0;
                flags.pd <= 1'b1;
                flags.to <= 1'b0;
            end else if (cmd.restart) begin
                cnt_q <= '0;
                flags <= '0;
            end else if (tick) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q    <= '0;
                    flags.to <= 1'b1;
                    if (flags.pd) evt.wake    <= 1'b1;
                    else          evt.rst_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wdog_dualclr.sv
module wdog_dualclr
    import wdog_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             two_cmd,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             halt,
    output logic             to_flag,
    output logic             pd_flag,
    output logic             rst_req,
    output logic             wake
);
    logic      fire;
    logic      tick;
    wd_cmd_t   cmd;
    wd_flags_t flags;
    wd_evt_t   evt;

    wdog_clr_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .two_cmd (two_cmd),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .halt    (halt),
        .fire    (fire)
    );

    assign cmd.halt    = halt;
    assign cmd.restart = fire;

    wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (halt | fire),
        .sel  (div_sel),
        .tick (tick)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cmd   (cmd),
        .flags (flags),
        .evt   (evt)
    );

    assign to_flag = flags.to;
    assign pd_flag = flags.pd;
    assign rst_req = evt.rst_req;
    assign wake    = evt.wake;

endmodule

// File: rtl/wdog_dualclr_chk.sv
module wdog_dualclr_chk (
    input logic clk,
    input logic rst,
    input logic two_cmd,
    input logic clr_a,
    input logic clr_b,
    input logic halt,
    input logic to_flag,
    input logic pd_flag,
    input logic rst_req,
    input logic wake
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !to_flag && !pd_flag && !rst_req && !wake);

    p_single_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (!two_cmd && !halt && (clr_a ^ clr_b)) |=> !to_flag && !pd_flag);

    p_halt_flags_r7: assert property (@(posedge clk) disable iff (rst)
        halt |=> pd_flag && !to_flag);

    p_rst_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> to_flag && !pd_flag);

    p_rst_req_single_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wake |-> to_flag && pd_flag && !rst_req);

    p_wake_single_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    p_to_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> (rst_req || wake));

    p_to_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !halt && !(clr_a ^ clr_b)) |=> to_flag);

endmodule

bind wdog_dualclr wdog_dualclr_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .two_cmd (two_cmd),
    .clr_a   (clr_a),
    .clr_b   (clr_b),
    .halt    (halt),
    .to_flag (to_flag),
    .pd_flag (pd_flag),
    .rst_req (rst_req),
    .wake    (wake)
);

// File: tb/wdog_dualclr_tb_top.sv
module wdog_dualclr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] div_sel = '0;
    logic       two_cmd = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       halt = 1'b0;
    logic       to_flag, pd_flag, rst_req, wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wdog_dualclr dut_i (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .two_cmd (two_cmd),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .halt    (halt),
        .to_flag (to_flag),
        .pd_flag (pd_flag),
        .rst_req (rst_req),
        .wake    (wake)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {to,pd,rst_req,wake} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs();
        return {to_flag, pd_flag, rst_req, wake};
    endfunction

    // One strobe cycle: the sampling edge is the one between the two falling edges
    task automatic cmd(input logic a, input logic b, input logic h);
        @(negedge clk);
        clr_a = a; clr_b = b; halt = h;
        @(negedge clk);
        clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        check("R1 reset state", outs(), 4'b0000);
        idle(255);
        check("R1 no early time-out", outs(), 4'b0000);
        idle(1);
        check("R1 first time-out at 256", outs(), 4'b1010);

        // R2/R3/R8: prescaler sweep in single-command mode
        for (int s = 0; s < 8; s++) begin
            div_sel = 3'(s);
            if (s % 2 == 0) cmd(1'b1, 1'b0, 1'b0);
            else            cmd(1'b0, 1'b1, 1'b0);
            check("R3 single clear", outs(), 4'b0000);
            idle((256 << s) - 1);
            check("R2 one edge before overflow", outs(), 4'b0000);
            idle(1);
            check("R2 R8 overflow edge", outs(), 4'b1010);
            idle(1);
            check("R8 pulse one cycle", outs(), 4'b1000);
        end

        // Paired mode at 1:1
        div_sel = 3'd0;
        two_cmd = 1'b1;
        cmd(1'b1, 1'b0, 1'b0);
        check("R4 first of pair keeps flag", outs(), 4'b1000);
        cmd(1'b0, 1'b1, 1'b0);
        check("R4 A then B clears", outs(), 4'b0000);
        // pair edge = 0; each cmd adds two edges
        idle(100);                 // edge 100
        cmd(1'b0, 1'b1, 1'b0);     // strobe on edge 102
        check("R6 lone strobe after pair", outs(), 4'b0000);
        cmd(1'b0, 1'b1, 1'b0);     // strobe on edge 104
        idle(151);                 // edge 255
        check("R5 R6 repeats ignored, no time-out yet", outs(), 4'b0000);
        idle(1);                   // edge 256
        check("R5 R6 time-out on original schedule", outs(), 4'b1010);
        cmd(1'b0, 1'b1, 1'b0);
        cmd(1'b0, 1'b1, 1'b0);
        check("R5 repeated B keeps flag", outs(), 4'b1000);
        cmd(1'b1, 1'b0, 1'b0);
        check("R4 B then A clears", outs(), 4'b0000);
        idle(255);
        check("R4 restart point", outs(), 4'b0000);
        idle(1);
        check("R4 time-out after pair", outs(), 4'b1010);

        // R10: both strobes together ignored in both modes
        cmd(1'b1, 1'b1, 1'b0);
        check("R10 both strobes, paired mode", outs(), 4'b1000);
        two_cmd = 1'b0;
        cmd(1'b1, 1'b1, 1'b0);
        check("R10 both strobes, single mode", outs(), 4'b1000);

        // R7/R9: halt and wake-up
        cmd(1'b0, 1'b0, 1'b1);
        check("R7 halt sets pd clears to", outs(), 4'b0100);
        idle(255);
        check("R9 before overflow in halt", outs(), 4'b0100);
        idle(1);
        check("R9 wake on overflow", outs(), 4'b1101);
        idle(1);
        check("R9 wake one cycle", outs(), 4'b1100);
        cmd(1'b1, 1'b0, 1'b1);
        check("R7 halt wins over clear", outs(), 4'b0100);
        cmd(1'b1, 1'b0, 1'b0);
        check("R3 single clear ends power-down", outs(), 4'b0000);

        // R7: halt empties the pending clear
        two_cmd = 1'b1;
        cmd(1'b1, 1'b0, 1'b0);
        cmd(1'b0, 1'b0, 1'b1);
        cmd(1'b0, 1'b1, 1'b0);
        check("R7 halt flushes pending A", outs(), 4'b0100);
        cmd(1'b1, 1'b0, 1'b0);
        check("R4 new pair after halt clears", outs(), 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule